// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address presented to a synchronous burst memory. At the start of a burst, either of two address strobes (one from a processor, one from a memory controller) captures a full external address into the block. Later accesses in the same burst do not need a new external address: each cycle in which the advance input is high, the block steps its two least-significant address bits through the next location of a four-location block.

Two step orders are supported, chosen by a static mode input. In linear order the low bits count up modulo four from the captured start. In interleaved order the low bits are the captured start XOR a running count of 0, 1, 2, 3. In both orders the sequence wraps inside the aligned four-location block. The upper address bits never change during a burst. The output address is taken straight from a register, so it changes only on a rising clock edge.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset `mem_addr` is all zeros.
- R2: A cycle with `strobe_proc` high loads `ext_addr` into `mem_addr`, visible after that rising edge.
- R3: A cycle with `strobe_ctrl` high loads `ext_addr` in the same way; both strobes high together also load.
- R4: With `order_xor` = 0, each advance (no strobe) sets the low two bits to (start + k) mod 4, where k is the number of advances since the load. For example, start 01 gives 01, 10, 11, 00.
- R5: With `order_xor` = 1, each advance sets the low two bits to start XOR (k mod 4). For example, start 01 gives 01, 00, 11, 10.
- R6: Advances never change `mem_addr` bits above bit 1. The low bits do not carry into them.
- R7: A strobe in the same cycle as `advance` performs a load, and the advance is discarded.
- R8: A cycle with no strobe and `advance` low leaves `mem_addr` unchanged.
- R9: After four advances following a load, the low bits equal the loaded start again, in either order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_addr | input | ADDR_W (17) | External start address |
| strobe_proc | input | 1 | Processor address strobe, active high |
| strobe_ctrl | input | 1 | Controller address strobe, active high |
| advance | input | 1 | Step to the next burst location, active high |
| order_xor | input | 1 | 1 selects interleaved order, 0 selects linear order |
| mem_addr | output | ADDR_W (17) | Current memory address, registered |

## Verification
The hardest case to reach is the wrap after the fourth advance from a start whose low bits are non-zero, in both orders. In that case the linear and interleaved sequences pass through different intermediate values and still have to return to the same start, with the upper bits left alone. Random stimulus alone seldom produces four advances in a row with no strobe between them. Directed bursts therefore load starts 01, 10 and 11 in each mode, give at least five advances each, and put upper bits of all ones into the address to expose any carry. A weighted random phase then mixes loads, advances, simultaneous strobe-plus-advance and idle cycles, and a bench model predicts the address each cycle.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    // Action taken by the sequencer on a clock edge.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_STEP = 2'd2
    } bseq_act_e;

endpackage

// File: rtl/bseq_decide.sv
module bseq_decide
    import bseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      strobe_proc,
    input  logic      strobe_ctrl,
    input  logic      advance,
    output bseq_act_e act
);

    logic any_strobe;

    always_comb begin
        any_strobe = strobe_proc | strobe_ctrl;
        if (any_strobe) begin
            act = ACT_LOAD;
        end else if (advance) begin
            act = ACT_STEP;
        end else begin
            act = ACT_HOLD;
        end
    end

    // R7
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_proc || strobe_ctrl) |-> act == ACT_LOAD);

endmodule

// File: rtl/bseq_order.sv
module bseq_order #(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] base,
    input  logic [CNT_W-1:0] count,
    input  logic             order_xor,
    output logic [CNT_W-1:0] lo
);

    logic [CNT_W-1:0] lin_lo;
    logic [CNT_W-1:0] xor_lo;

    // Interleaved order flips base bits by the count bits, bit by bit.
    for (genvar b = 0; b < CNT_W; b++) begin : g_xor
        assign xor_lo[b] = base[b] ^ count[b];
    end

    // Linear order adds with natural wrap at CNT_W bits.
    assign lin_lo = base + count;

    assign lo = order_xor ? xor_lo : lin_lo;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              strobe_proc,
    input  logic              strobe_ctrl,
    input  logic              advance,
    input  logic              order_xor,
    output logic [ADDR_W-1:0] mem_addr
);

    localparam int HI_W = ADDR_W - CNT_W;

    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [CNT_W-1:0] base;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lo;
    } seq_state_t;

    seq_state_t st_d, st_q;
    bseq_act_e  act;
    logic [CNT_W-1:0] step_lo;
    logic [CNT_W-1:0] cnt_next;

    bseq_decide u_decide (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_proc (strobe_proc),
        .strobe_ctrl (strobe_ctrl),
        .advance     (advance),
        .act         (act)
    );

    assign cnt_next = st_q.cnt + 1'b1;

    bseq_order #(.CNT_W(CNT_W)) u_order (
        .base      (st_q.base),
        .count     (cnt_next),
        .order_xor (order_xor),
        .lo        (step_lo)
    );

    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_LOAD: begin
                st_d.hi   = ext_addr[ADDR_W-1:CNT_W];
                st_d.base = ext_addr[CNT_W-1:0];
                st_d.cnt  = '0;
                st_d.lo   = ext_addr[CNT_W-1:0];
            end
            ACT_STEP: begin
                st_d.cnt = cnt_next;
                st_d.lo  = step_lo;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr = {st_q.hi, st_q.lo};

    // R2
    load_proc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_proc |=> mem_addr == $past(ext_addr));

    // R3
    load_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_ctrl |=> mem_addr == $past(ext_addr));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_proc && !strobe_ctrl && !advance) |=> $stable(mem_addr));

    // R6
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !strobe_proc && !strobe_ctrl)
        |=> mem_addr[ADDR_W-1:CNT_W] == $past(mem_addr[ADDR_W-1:CNT_W]));

    // R4
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !strobe_proc && !strobe_ctrl && !order_xor)
        |=> mem_addr[CNT_W-1:0] == CNT_W'($past(mem_addr[CNT_W-1:0]) + 1'b1));

    // R9
    wrap_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !strobe_proc && !strobe_ctrl && st_q.cnt == {CNT_W{1'b1}})
        |=> mem_addr[CNT_W-1:0] == st_q.base);

endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          strobe_proc = 1'b0;
    logic          strobe_ctrl = 1'b0;
    logic          advance = 1'b0;
    logic          order_xor = 1'b0;
    logic [AW-1:0] mem_addr;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Bench model
    logic [AW-3:0] m_hi = '0;
    logic [1:0]    m_base = '0;
    logic [1:0]    m_cnt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq u0 (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
        .strobe_proc(strobe_proc), .strobe_ctrl(strobe_ctrl),
        .advance(advance), .order_xor(order_xor), .mem_addr(mem_addr)
    );

    function automatic logic [1:0] exp_lo(input logic [1:0] b, input logic [1:0] k, input logic x);
        return x ? (b ^ k) : 2'(b + k);
    endfunction

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, model the edge, check after it.
    task automatic cycle(input logic sp, input logic sc, input logic adv,
                         input logic [AW-1:0] a, input logic x);
        string tag;
        logic [AW-1:0] prev;
        @(negedge clk);
        prev = mem_addr;
        strobe_proc = sp; strobe_ctrl = sc; advance = adv; ext_addr = a; order_xor = x;
        if (sp || sc) begin
            m_hi = a[AW-1:2]; m_base = a[1:0]; m_cnt = 2'd0;
            tag = adv ? "R7" : (sp ? "R2" : "R3");
        end else if (adv) begin
            m_cnt = m_cnt + 2'd1;
            tag = (m_cnt == 2'd0) ? "R9" : (x ? "R5" : "R4");
        end else begin
            tag = "R8";
        end
        @(posedge clk);
        #1;
        check(tag, mem_addr, {m_hi, exp_lo(m_base, m_cnt, x)});
        if (adv && !sp && !sc) check("R6", {mem_addr[AW-1:2], 2'b00}, {prev[AW-1:2], 2'b00});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        logic mode;
        seed = 1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1;
        check("R1", mem_addr, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed bursts: each start, each mode, five advances, high bits all ones.
        for (int m = 0; m < 2; m++) begin
            for (int s = 1; s < 4; s++) begin
                logic [AW-1:0] a;
                a = {{(AW-2){1'b1}}, 2'(s)};
                cycle(s[0], ~s[0], 1'b0, a, m[0]);
                for (int k = 0; k < 5; k++) cycle(1'b0, 1'b0, 1'b1, '0, m[0]);
                cycle(1'b0, 1'b0, 1'b0, '1, m[0]);
            end
        end
        // Both strobes together, and strobe with advance.
        cycle(1'b1, 1'b1, 1'b0, 17'h0ABC6, 1'b0);
        cycle(1'b1, 1'b0, 1'b1, 17'h15553, 1'b1);
        cycle(1'b0, 1'b1, 1'b1, 17'h00001, 1'b1);

        // Weighted random phase; mode changes only together with a load.
        mode = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            int r;
            logic sp, sc, adv;
            r = $urandom_range(0, 9);
            sp = (r == 0) || (r == 2);
            sc = (r == 1) || (r == 2);
            adv = (r >= 3 && r <= 7) || (r == 2 && $urandom_range(0, 1) == 1);
            if (sp || sc) mode = 1'($urandom_range(0, 1));
            cycle(sp, sc, adv, AW'($urandom), mode);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule